// File: doc/BRIEF.md
# Start-Stop Tick Generator

This block derives the count-enable strobe for a two-digit timer from a free-running system clock. One pushbutton input acts as a toggle. Each rising edge starts a stopped timer or stops a running one. An indicator output shows whether the timer is running. While it runs, the block raises a single-cycle tick once per second. Holding a second button raises the rate to ten ticks per second. A blink output changes state on every tick, so counting activity can be seen, and it flickers visibly at the fast rate.

The clock frequency is a parameter. A prescaler divides it down to a base strobe at the fast rate, and a decade stage divides that strobe again to give the slow rate. The level of the fast button picks which strobe is sent out. The buttons are not debounced. A bouncing contact that makes several rising edges therefore toggles the run state once for each edge. While the timer is stopped, both dividers are held at zero, so the first tick after a start always comes one full period later.

Top module: `start_stop_ticker`

## Requirements
- R1: A synchronous active-high `rst` clears the run state and both dividers, so `runLed`, `tickEn` and `blinkLed` read 0 on the cycle after reset.
- R2: Each rising edge of `startStopBtn` toggles the run state exactly once. The new state appears on `runLed` after the third rising clock edge at which the button is sampled high. Holding the button high counts as one press.
- R3: `runLed` is 1 while running and 0 while stopped.
- R4: While running with `fastBtn` low, `tickEn` pulses once every CLK_HZ cycles. The first pulse comes in the CLK_HZ-th cycle in which `runLed` reads 1.
- R5: While running with `fastBtn` high, `tickEn` pulses once every CLK_HZ/FAST_HZ cycles. The first pulse comes in the (CLK_HZ/FAST_HZ)-th cycle in which `runLed` reads 1.
- R6: While stopped, `tickEn` stays 0 whatever `fastBtn` does, and both dividers are held at zero, so every start begins a full period.
- R7: `tickEn` is never high for two cycles in a row.
- R8: `blinkLed` inverts on the clock edge that ends each `tickEn` cycle and holds its value otherwise.
- R9: No debounce is done. Several rising edges in a burst, each at least one clock cycle apart, each toggle the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| startStopBtn | input | 1 | Raw start/stop pushbutton level; each rising edge is a press |
| fastBtn | input | 1 | Raw fast-rate button level; high selects the fast rate |
| runLed | output | 1 | High while the timer is running |
| tickEn | output | 1 | One-cycle count-enable pulse |
| blinkLed | output | 1 | Inverts on every tick |

## Verification
If the run flag toggles wrongly, `runLed` goes wrong within three cycles of a press. A press that is counted twice or missed also leaves the bench waiting for ticks that never come. A prescaler or decade counter that is not cleared on stop shows up on the next start: the first `tickEn` arrives earlier than a full period, which is caught at the exact cycle index. A miscounting divider changes the number of ticks in a fixed window within one period. A blink register that misses a toggle shows up as a parity mismatch at the end of each window.

// File: rtl/ticker_pkg.sv
package ticker_pkg;
  // Strobes and levels passed from control to datapath
  typedef struct packed {
    logic holdDiv;  // keep dividers at zero (stopped)
    logic fastSel;  // synchronised fast-rate select
  } tickCtrl_t;
endpackage

// File: rtl/ticker_ctrl.sv
module ticker_ctrl
  import ticker_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startStopBtn,
  input  logic      fastBtn,
  output tickCtrl_t ctrl,
  output logic      runLed
);
  logic [1:0] ssSync;
  logic       ssPrev;
  logic [1:0] fastSync;
  logic       runQ;
  logic       press;

  assign press = ssSync[1] & ~ssPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ssSync   <= '0;
      ssPrev   <= 1'b0;
      fastSync <= '0;
      runQ     <= 1'b0;
    end else begin
      ssSync   <= {ssSync[0], startStopBtn};
      ssPrev   <= ssSync[1];
      fastSync <= {fastSync[0], fastBtn};
      if (press) runQ <= ~runQ;
    end
  end

  always_comb begin
    ctrl.holdDiv = ~runQ;
    ctrl.fastSel = fastSync[1];
  end
  assign runLed = runQ;

  AST_PRESS_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    press |=> (runQ != $past(runQ))); // R2
  AST_NO_PRESS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(runQ)); // R9
endmodule

// File: rtl/ticker_datapath.sv
module ticker_datapath
  import ticker_pkg::*;
#(
  parameter int BASE_DIV   = 5_000_000,
  parameter int SLOW_RATIO = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  tickCtrl_t ctrl,
  output logic      tickEn,
  output logic      blinkLed
);
  localparam int PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             baseHit;
  logic             slowHit;
  logic             blinkQ;

  assign baseHit = ~ctrl.holdDiv & (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || ctrl.holdDiv) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  generate
    if (SLOW_RATIO > 1) begin : g_decade
      localparam int DEC_W = $clog2(SLOW_RATIO);
      localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(SLOW_RATIO - 1);
      logic [DEC_W-1:0] decCnt;

      always_ff @(posedge clk) begin
        if (rst || ctrl.holdDiv) decCnt <= '0;
        else if (baseHit) decCnt <= (decCnt == DEC_LAST) ? '0 : decCnt + 1'b1;
      end
      assign slowHit = baseHit & (decCnt == DEC_LAST);

      AST_DEC_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.holdDiv) |-> (decCnt == '0)); // R6
    end else begin : g_nodecade
      assign slowHit = baseHit;
    end
  endgenerate

  assign tickEn = ctrl.fastSel ? baseHit : slowHit;

  always_ff @(posedge clk) begin
    if (rst) blinkQ <= 1'b0;
    else if (tickEn) blinkQ <= ~blinkQ;
  end
  assign blinkLed = blinkQ;

  AST_PRE_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl.holdDiv) |-> (preCnt == '0)); // R6
  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    preCnt <= PRE_LAST); // R5
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> !tickEn); // R7
  AST_BLINK_FLIP: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> (blinkQ != $past(blinkQ))); // R8
  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(blinkQ)); // R8
endmodule

// File: rtl/start_stop_ticker.sv
module start_stop_ticker
  import ticker_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int FAST_HZ    = 10,
  parameter int SLOW_RATIO = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic startStopBtn,
  input  logic fastBtn,
  output logic runLed,
  output logic tickEn,
  output logic blinkLed
);
  localparam int BASE_DIV = CLK_HZ / FAST_HZ;

  tickCtrl_t ctrl;

  ticker_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .startStopBtn (startStopBtn),
    .fastBtn      (fastBtn),
    .ctrl         (ctrl),
    .runLed       (runLed)
  );

  ticker_datapath #(
    .BASE_DIV   (BASE_DIV),
    .SLOW_RATIO (SLOW_RATIO)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .tickEn   (tickEn),
    .blinkLed (blinkLed)
  );

  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !runLed |-> !tickEn); // R6
endmodule

// File: tb/start_stop_ticker_test.sv
module start_stop_ticker_test;
  localparam int CLK_HZ = 200;
  localparam int FAST_P = 20;
  localparam int SLOW_P = 200;
  localparam int NVEC   = 6;

  localparam bit VEC_FAST  [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int VEC_LEN   [NVEC] = '{100, 119, 199, 650, 120, 200};
  localparam int VEC_TICKS [NVEC] = '{5, 5, 0, 3, 6, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startStopBtn = 1'b0;
  logic fastBtn = 1'b0;
  logic runLed, tickEn, blinkLed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  start_stop_ticker #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .startStopBtn(startStopBtn), .fastBtn(fastBtn),
    .runLed(runLed), .tickEn(tickEn), .blinkLed(blinkLed)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Rising edge, held three clock edges, then released; returns at the negedge
  // where the new run state is visible.
  task automatic pressBtn();
    @(negedge clk) startStopBtn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) startStopBtn = 1'b0;
  endtask

  task automatic countTicks(input int len, output int ticks, output int first,
                            output bit dbl, output bit blinkOk);
    bit prevTick = 1'b0;
    bit blinkStart = blinkLed;
    ticks = 0; first = -1; dbl = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (tickEn) begin
        if (first < 0) first = i;
        ticks++;
        if (prevTick) dbl = 1'b1;
      end
      prevTick = tickEn;
      @(posedge clk); @(negedge clk);
    end
    blinkOk = (blinkLed == (blinkStart ^ ticks[0]));
  endtask

  initial begin
    int t, f; bit d, b;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check(runLed == 0 && tickEn == 0 && blinkLed == 0, "R1 reset", {runLed, tickEn, blinkLed}, 0);

    // R6 stopped: no ticks in either rate
    fastBtn = 1'b1;
    countTicks(150, t, f, d, b);
    check(t == 0, "R6 stopped fast", t, 0);
    fastBtn = 1'b0;
    countTicks(250, t, f, d, b);
    check(t == 0, "R6 stopped slow", t, 0);

    // R2 exact latency of a press
    @(negedge clk) startStopBtn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(runLed == 0, "R2 not yet toggled", runLed, 0);
    @(posedge clk); @(negedge clk);
    check(runLed == 1, "R2 toggled on third edge", runLed, 1);
    // R2 holding the button counts once
    repeat (10) @(posedge clk);
    @(negedge clk) startStopBtn = 1'b0;
    check(runLed == 1, "R2 held counts once", runLed, 1);
    pressBtn();
    check(runLed == 0, "R3 stopped indicator", runLed, 0);
    repeat (5) @(negedge clk);

    // Vector table: each row starts from stopped
    for (int v = 0; v < NVEC; v++) begin
      int period;
      period = VEC_FAST[v] ? FAST_P : SLOW_P;
      @(negedge clk) fastBtn = VEC_FAST[v];
      repeat (4) @(negedge clk);
      pressBtn();
      check(runLed == 1, "R3 running indicator", runLed, 1);
      countTicks(VEC_LEN[v], t, f, d, b);
      check(t == VEC_TICKS[v], VEC_FAST[v] ? "R5 fast tick count" : "R4 slow tick count", t, VEC_TICKS[v]);
      if (VEC_TICKS[v] > 0)
        check(f == period - 1, VEC_FAST[v] ? "R5 first fast tick R6" : "R4 first slow tick R6", f, period - 1);
      check(!d, "R7 single-cycle tick", d, 0);
      check(b, "R8 blink parity", b, 1);
      pressBtn();
      check(runLed == 0, "R3 stop indicator", runLed, 0);
      countTicks(40, t, f, d, b);
      check(t == 0, "R6 no ticks after stop", t, 0);
    end

    // R9 bounce: three rising edges start the timer
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) startStopBtn = 1'b1;
      @(negedge clk) startStopBtn = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(runLed == 1, "R9 three edges toggle thrice", runLed, 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk) startStopBtn = 1'b1;
      @(negedge clk) startStopBtn = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(runLed == 1, "R9 two edges cancel", runLed, 1);

    // R1 reset while running
    fastBtn = 1'b1;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(runLed == 0 && tickEn == 0, "R1 reset mid-run", {runLed, tickEn}, 0);
    rst = 1'b0;
    countTicks(60, t, f, d, b);
    check(t == 0, "R1 stays stopped after reset", t, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule